// File: doc/BRIEF.md
# Byte-Lane RAM Port With Selectable Output Pipeline

This block is the control and data path of one port of a synchronous RAM that is two 9-bit byte lanes wide. On each rising clock edge it registers a pair of chip selects of opposite polarity, a read/not-write line, one active-low select per byte lane, the address and the write data. From these registered values it forms per-lane write strobes into its own storage array. It also forms per-lane output-drive signals for read data. The output-enable input bypasses the registers and gates the drive signals directly.

A static mode input picks one of two output timings. In flow-through timing, read data for an address registered at an edge is presented right after that edge. In pipelined timing the data passes through one more register, so it is presented one edge later. Tri-state pins are represented by a data-out bus plus one drive-enable bit per lane. A lane that is not driven shows zero on the data-out bus. The address is assumed to come from a separate counter block. The array depth is a parameter: a full-size instance uses a 16-bit address, and the default is kept small.

Top module: `bytelane_port`

## Requirements
- R1: The port is selected only when `cs_n` is 0 and `cs` is 1 at a clock edge. A deselected edge writes nothing and turns off both bits of `lane_oe` right after that edge, in both modes.
- R2: The upper lane is data bits 17..9, selected by `up_n` = 0. The lower lane is bits 8..0, selected by `lo_n` = 0. A selected write (`rnw` = 0) stores only the lanes whose select is 0, so with both selects at 1 nothing is stored.
- R3: A selected read (`rnw` = 1) drives only its selected lanes: `lane_oe[1]` is the upper lane and `lane_oe[0]` the lower lane. Bits of `rdata` in a lane that is not driven are 0.
- R4: `oe_n` = 1 forces `lane_oe` to 0 at once, without waiting for a clock edge. Returning it to 0 restores the drive.
- R5: With `mode_pipe` = 0, the data of a read registered at an edge is on `rdata` right after that same edge.
- R6: With `mode_pipe` = 1, read data and its lane enables appear one edge later than with `mode_pipe` = 0.
- R7: With `mode_pipe` = 1, after a deselect the outputs drive again only after two consecutive selected read edges.
- R8: The outputs of a cycle follow the controls registered one access earlier. With `mode_pipe` = 1, a write registered just after a read still drives that read's data. With `mode_pipe` = 0, a write cycle drives nothing.
- R9: In either mode, a read of the address written by the previous access returns the newly written lanes merged with the lanes that were kept.
- R10: While the address and controls stay unchanged, `rdata` and `lane_oe` stay constant across clock edges.
- R11: After reset, `lane_oe` is 0 and `rdata` is 0. Array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control path |
| mode_pipe | input | 1 | Static output timing: 0 flow-through, 1 pipelined |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| rnw | input | 1 | 1 read, 0 write |
| up_n | input | 1 | Active-low select of lane bits 17..9 |
| lo_n | input | 1 | Active-low select of lane bits 8..0 |
| oe_n | input | 1 | Active-low output enable, not registered |
| addr | input | ADDR_W | Word address from the counter block |
| wdata | input | 2*LANE_W | Write data |
| rdata | output | 2*LANE_W | Read data, zero in undriven lanes |
| lane_oe | output | 2 | Per-lane drive enable, bit 1 upper, bit 0 lower |

## Verification
With pipelined timing, two things overlap in one clock edge. The array write for an access registered one edge earlier happens at the same edge where the output register captures the array word for the next access. The bench issues write-then-read and read-then-write pairs on one address back to back. It checks two things: the read that follows a write sees the new lanes one edge later, and a read followed at once by a write still presents the old word during the write cycle. A second overlap is a deselect arriving while pipelined read data is still in flight. That case is judged by requiring `lane_oe` to drop right after the deselect edge and to stay off for exactly one further selected edge.

// File: rtl/blp_pkg.sv
package blp_pkg;

    typedef enum logic {
        OUT_FLOW = 1'b0,
        OUT_PIPE = 1'b1
    } out_mode_e;

    localparam int unsigned LANE_CNT = 2;

    function automatic logic port_selected(input logic sel_low_n, input logic sel_high);
        return (~sel_low_n) & sel_high;
    endfunction

endpackage

// File: rtl/blp_in_reg.sv
module blp_in_reg #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      cs,
    input  logic                      rnw,
    input  logic [LANES-1:0]          lane_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic                      sel_q,
    output logic                      wr_q,
    output logic [LANES-1:0]          lane_q,
    output logic [ADDR_W-1:0]         addr_q,
    output logic [LANES*LANE_W-1:0]   wdata_q
);
    import blp_pkg::*;

    localparam int unsigned DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic               sel;
        logic               wr;
        logic [LANES-1:0]   lane;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
    } in_t;

    in_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sel  = port_selected(cs_n, cs);
        st_d.wr   = ~rnw;
        st_d.lane = ~lane_n;
        st_d.addr = addr;
        st_d.data = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_q   = st_q.sel;
    assign wr_q    = st_q.wr;
    assign lane_q  = st_q.lane;
    assign addr_q  = st_q.addr;
    assign wdata_q = st_q.data;

endmodule

// File: rtl/blp_decode.sv
module blp_decode #(
    parameter int unsigned LANES = 2
) (
    input  logic             sel,
    input  logic             wr,
    input  logic [LANES-1:0] lane,
    output logic [LANES-1:0] wr_lane,
    output logic [LANES-1:0] rd_lane
);
    always_comb begin
        wr_lane = '0;
        rd_lane = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            wr_lane[i] = sel & wr & lane[i];
            rd_lane[i] = sel & ~wr & lane[i];
        end
    end

endmodule

// File: rtl/blp_array.sv
module blp_array #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 2
) (
    input  logic                     clk,
    input  logic [LANES-1:0]         wr_lane,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lane[g]) mem_q[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem_q[addr];
    end

endmodule

// File: rtl/blp_out_stage.sv
module blp_out_stage #(
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_pipe,
    input  logic                     oe_n,
    input  logic                     sel_now,
    input  logic [LANES-1:0]         rd_lane,
    input  logic [LANES*LANE_W-1:0]  arr_data,
    output logic [LANES-1:0]         lane_oe,
    output logic [LANES*LANE_W-1:0]  rdata
);
    import blp_pkg::*;

    localparam int unsigned DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic [LANES-1:0]  lane;
        logic [DATA_W-1:0] data;
    } pipe_t;

    pipe_t pp_d, pp_q;
    logic [LANES-1:0]  vld;
    logic [DATA_W-1:0] src;

    always_comb begin
        pp_d      = pp_q;
        pp_d.lane = rd_lane;
        pp_d.data = arr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    always_comb begin
        if (out_mode_e'(mode_pipe) == OUT_PIPE) begin
            vld = pp_q.lane & {LANES{sel_now}};
            src = pp_q.data;
        end else begin
            vld = rd_lane;
            src = arr_data;
        end
    end

    for (genvar g = 0; g < int'(LANES); g++) begin : g_drv
        assign lane_oe[g] = vld[g] & ~oe_n;
        assign rdata[g*LANE_W +: LANE_W] = lane_oe[g] ? src[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/bytelane_port.sv
module bytelane_port #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANE_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_pipe,
    input  logic                   cs_n,
    input  logic                   cs,
    input  logic                   rnw,
    input  logic                   up_n,
    input  logic                   lo_n,
    input  logic                   oe_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [2*LANE_W-1:0]    wdata,
    output logic [2*LANE_W-1:0]    rdata,
    output logic [1:0]             lane_oe
);
    import blp_pkg::*;

    localparam int unsigned LANES  = LANE_CNT;
    localparam int unsigned DATA_W = LANES * LANE_W;

    logic                sel_q;
    logic                wr_q;
    logic [LANES-1:0]    lane_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [LANES-1:0]    wr_lane;
    logic [LANES-1:0]    rd_lane;
    logic [DATA_W-1:0]   arr_data;

    blp_in_reg #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .cs      (cs),
        .rnw     (rnw),
        .lane_n  ({up_n, lo_n}),
        .addr    (addr),
        .wdata   (wdata),
        .sel_q   (sel_q),
        .wr_q    (wr_q),
        .lane_q  (lane_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q)
    );

    blp_decode #(.LANES(LANES)) u_dec (
        .sel     (sel_q),
        .wr      (wr_q),
        .lane    (lane_q),
        .wr_lane (wr_lane),
        .rd_lane (rd_lane)
    );

    blp_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
        .clk     (clk),
        .wr_lane (wr_lane),
        .addr    (addr_q),
        .wdata   (wdata_q),
        .rdata   (arr_data)
    );

    blp_out_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_pipe (mode_pipe),
        .oe_n      (oe_n),
        .sel_now   (sel_q),
        .rd_lane   (rd_lane),
        .arr_data  (arr_data),
        .lane_oe   (lane_oe),
        .rdata     (rdata)
    );

endmodule

// File: rtl/blp_checker.sv
module blp_checker #(
    parameter int unsigned LANE_W = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mode_pipe,
    input logic                 cs_n,
    input logic                 cs,
    input logic                 rnw,
    input logic                 up_n,
    input logic                 oe_n,
    input logic [2*LANE_W-1:0]  rdata,
    input logic [1:0]           lane_oe
);
    logic sel_in;
    assign sel_in = ~cs_n & cs;

    // R1: a deselected edge leaves no lane driven after it
    p_deselect_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sel_in) |-> (lane_oe == 2'b00));

    // R4: output enable high blocks every lane
    p_oe_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (lane_oe == 2'b00));

    // R8: flow-through write cycle drives nothing
    p_flow_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_pipe && $past(sel_in && !rnw)) |-> (lane_oe == 2'b00));

    // R2: flow-through upper lane stays off when its select was high
    p_flow_upper_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_pipe && $past(up_n)) |-> !lane_oe[1]);

    // R7: pipelined reselect needs a second selected edge
    p_pipe_reselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_pipe && $past(sel_in) && !$past(sel_in, 2)) |-> (lane_oe == 2'b00));

    // R3: undriven lanes carry zero
    p_idle_lane_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lane_oe[0] |-> (rdata[LANE_W-1:0] == '0)) and
        (!lane_oe[1] |-> (rdata[2*LANE_W-1:LANE_W] == '0)));

endmodule

bind bytelane_port blp_checker #(.LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_pipe (mode_pipe),
    .cs_n      (cs_n),
    .cs        (cs),
    .rnw       (rnw),
    .up_n      (up_n),
    .oe_n      (oe_n),
    .rdata     (rdata),
    .lane_oe   (lane_oe)
);

// File: tb/tb_bytelane_port.sv
module tb_bytelane_port;

    localparam int AW = 10;
    localparam int LW = 9;
    localparam int DW = 2 * LW;
    localparam int NV = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_pipe = 1'b0;
    logic          cs_n = 1'b1;
    logic          cs = 1'b0;
    logic          rnw = 1'b1;
    logic          up_n = 1'b1;
    logic          lo_n = 1'b1;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [1:0]    lane_oe;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bytelane_port #(.ADDR_W(AW), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe),
        .cs_n(cs_n), .cs(cs), .rnw(rnw), .up_n(up_n), .lo_n(lo_n),
        .oe_n(oe_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .lane_oe(lane_oe)
    );

    // {cs_n, cs, rnw, up_n, lo_n, oe_n, addr, wdata, exp_oe, exp_rdata}
    localparam logic [53:0] VEC [NV] = '{
        {6'b010000, 10'd5,    18'h2A5A5, 2'b00, 18'h00000}, // R8 write quiet
        {6'b011000, 10'd5,    18'h00000, 2'b11, 18'h2A5A5}, // R5 R9
        {6'b010010, 10'd5,    18'h3FFFF, 2'b00, 18'h00000}, // upper only write
        {6'b011000, 10'd5,    18'h00000, 2'b11, 18'h3FFA5}, // R2 R9
        {6'b011100, 10'd5,    18'h00000, 2'b01, 18'h001A5}, // R3 lower only
        {6'b011000, 10'd5,    18'h00000, 2'b11, 18'h3FFA5},
        {6'b011000, 10'd5,    18'h00000, 2'b11, 18'h3FFA5}, // R10
        {6'b111000, 10'd5,    18'h00000, 2'b00, 18'h00000}, // R1 cs_n high
        {6'b001000, 10'd5,    18'h00000, 2'b00, 18'h00000}, // R1 cs low
        {6'b010100, 10'd9,    18'h3FF00, 2'b00, 18'h00000}, // lower only write
        {6'b011100, 10'd9,    18'h00000, 2'b01, 18'h00100}, // R2
        {6'b010110, 10'd5,    18'h00000, 2'b00, 18'h00000}, // no lane write
        {6'b011000, 10'd5,    18'h00000, 2'b11, 18'h3FFA5}, // R2 nothing stored
        {6'b011110, 10'd5,    18'h00000, 2'b00, 18'h00000}, // R3 no lanes
        {6'b010000, 10'd1023, 18'h12345, 2'b00, 18'h00000}, // top address
        {6'b011000, 10'd1023, 18'h00000, 2'b11, 18'h12345}, // R5
        {6'b011001, 10'd1023, 18'h00000, 2'b00, 18'h00000}, // R4
        {6'b110000, 10'd5,    18'h00000, 2'b00, 18'h00000}, // R1 deselected write
        {6'b011000, 10'd5,    18'h00000, 2'b11, 18'h3FFA5}  // R1 not stored
    };

    function automatic string row_req(input int i);
        case (i)
            0:       return "R8";
            1:       return "R5";
            3, 12:   return "R2";
            4, 13:   return "R3";
            6:       return "R10";
            7, 8, 17, 18: return "R1";
            10:      return "R2";
            15:      return "R5";
            16:      return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic chk(input string req, input logic [1:0] exp_oe, input logic [DW-1:0] exp_rd);
        n_run++;
        if (lane_oe !== exp_oe || rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s: lane_oe=%b rdata=%h expected lane_oe=%b rdata=%h",
                     req, lane_oe, rdata, exp_oe, exp_rd);
        end
    endtask

    task automatic cyc(input logic c_n, input logic c, input logic r, input logic u, input logic l,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cs_n = c_n; cs = c; rnw = r; up_n = u; lo_n = l; oe_n = 1'b0;
        addr = a; wdata = d;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic pipe);
        @(negedge clk);
        rst_n = 1'b0;
        mode_pipe = pipe;
        cs_n = 1'b1; cs = 1'b0; rnw = 1'b1; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #(200000 * 8);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R11 reset", 2'b00, '0);
        do_reset(1'b0);
        chk("R11 after reset", 2'b00, '0);

        // table walk, flow-through timing
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {cs_n, cs, rnw, up_n, lo_n, oe_n} = VEC[i][53:48];
            addr  = VEC[i][47:38];
            wdata = VEC[i][37:20];
            @(posedge clk);
            #2;
            chk(row_req(i), VEC[i][19:18], VEC[i][17:0]);
        end

        // R4: oe_n acts without a clock edge
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd1023, '0);
        oe_n = 1'b1;
        #1;
        chk("R4 async off", 2'b00, '0);
        oe_n = 1'b0;
        #1;
        chk("R4 async on", 2'b11, 18'h12345);

        // pipelined timing
        do_reset(1'b1);
        chk("R11 pipe reset", 2'b00, '0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd7, 18'h0BEEF);
        chk("R8 pipe write", 2'b00, '0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd7, '0);
        chk("R6 first edge", 2'b00, '0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd7, '0);
        chk("R6 second edge", 2'b11, 18'h0BEEF);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd7, '0);
        chk("R10 pipe hold", 2'b11, 18'h0BEEF);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'd7, 18'h15555);
        chk("R8 read then write", 2'b11, 18'h0BEEF);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd7, '0);
        chk("R6 after write", 2'b00, '0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd7, '0);
        chk("R9 pipe new data", 2'b11, 18'h15555);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 10'd7, '0);
        chk("R7 deselect", 2'b00, '0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd7, '0);
        chk("R7 first reselect", 2'b00, '0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 10'd7, '0);
        chk("R7 second reselect", 2'b11, 18'h15555);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd7, '0);
        chk("R6 lane change delayed", 2'b11, 18'h15555);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd7, '0);
        chk("R3 pipe lower only", 2'b01, 18'h00155);
        oe_n = 1'b1;
        #1;
        chk("R4 pipe async off", 2'b00, '0);
        oe_n = 1'b0;
        #1;
        chk("R4 pipe async on", 2'b01, 18'h00155);

        summary();
        $finish;
    end

endmodule